// File: doc/BRIEF.md
# Transmit DMA Channel Status and Error Unit

This unit holds the host-visible control and status state for a bank of transmit DMA channels. Each channel has a configuration register that selects its run mode and whether internal credit requests are enabled, plus a credit counter. The counter rises on each credit grant and falls on each request the channel issues. The data movers outside the unit read the decoded mode and credit-enable outputs and return their per-channel buffer-empty and no-pending-request flags. The unit packs those flags into one status word and reports a channel as idle when both of its flags are high.

A shared error register records faults as sticky bits. There is one bit per channel for an activate command that reaches a channel whose request buffer is already full. There is one bit per channel for a FIFO-full indication that arrives while that channel's credit counter is not zero, which means the credit accounting has drifted from the FIFO. There are also two global bits: an internal memory address fault and a wrong dword count from the host. The host clears any error bit by writing 1 to it. Register reads are combinational from the address; writes take effect on the next rising clock edge.

Register map (byte offsets): channel n configuration at n*0x20, channel n credit count (read-only) at n*0x20+0x04, status word at 0x100, error register at 0x108. Any other address reads 0.

Top module: `txdma_stat_unit`

## Requirements
- R1: After reset every configuration register, every credit counter and the error register read 0.
- R2: A write to channel n's configuration address (n*0x20) stores only bits 31:30 and bit 3. All other bits read back 0, and no other channel's register changes.
- R3: Configuration bits 31:30 select the mode: 00 off, 01 pause at end of frame, 10 normal. Bit n of run_o is high in mode 10, bit n of eof_pause_o is high in mode 01, and bit n of credit_en_o follows configuration bit 3.
- R4: In a mode other than off, the credit counter (read at n*0x20+0x04) goes up by one on a grant and down by one on an issued request. When both arrive in the same cycle, it stays unchanged.
- R5: While a channel's mode is off (00), its credit counter is held at 0 and grants are ignored.
- R6: The credit counter saturates: it does not go below 0 and does not go above 2^CRED_W-1.
- R7: The status word at 0x100 carries the buffer-empty flags in bits 31:24 and the no-pending flags in bits 23:16, with all other bits 0. idle_o bit n is the AND of channel n's two flags.
- R8: Error bit n (bits 7:0) sets when fifo_full_i[n] is high while channel n's credit counter is non-zero. It does not set when the counter is 0.
- R9: Error bit 9+n (bits 16:9) sets when act_cmd_i[n] is high while req_buf_full_i[n] is high. It does not set when the buffer is not full.
- R10: Error bit 31 sets on addr_err_i and error bit 30 sets on dword_err_i.
- R11: Error bits are sticky and clear only when the host writes 1 to them. Writing 0 leaves them unchanged, and the unused bits (29:17, 8) always read 0.
- R12: If an error event and a host write-one-to-clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| credit_grant_i | input | N_CH | Per-channel credit grant pulse |
| req_issue_i | input | N_CH | Per-channel issued-request pulse |
| act_cmd_i | input | N_CH | Per-channel activate command from scheduler |
| req_buf_full_i | input | N_CH | Per-channel request buffer full |
| fifo_full_i | input | N_CH | Per-channel transmit FIFO full indication |
| buf_empty_i | input | N_CH | Per-channel buffers-empty flag |
| no_pend_i | input | N_CH | Per-channel no-pending-request flag |
| addr_err_i | input | 1 | Internal memory address fault pulse |
| dword_err_i | input | 1 | Host dword-count mismatch pulse |
| run_o | output | N_CH | Channel in normal mode |
| eof_pause_o | output | N_CH | Channel in pause-at-end-of-frame mode |
| credit_en_o | output | N_CH | Channel credit requests enabled |
| idle_o | output | N_CH | Channel idle (empty and no pending) |

## Verification
The credit counter is driven with lone grants, lone requests, grants and requests in the same cycle, a long grant run into the upper limit and a request at zero. These patterns separate correct up/down counting from a counter that ignores the both-at-once case or wraps. Credit-error detection is tried on two channels in the same cycle, one with a non-zero count and one at zero, and the activate check is tried with the buffer full on one channel and not full on another, so that a bit which ignores its qualifier shows up. The error register is cleared with 0, with a single 1 and with all ones, and once in the same cycle as a new event, which separates true write-one-to-clear from plain write and from clear-wins priority.

// File: rtl/txdma_stat_pkg.sv
package txdma_stat_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EOF = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } ch_mode_e;

  localparam logic [31:0] CFG_MASK   = 32'hC000_0008;
  localparam int          CH_STRIDE  = 'h20;
  localparam int          CRED_OFS   = 'h04;
  localparam int          STAT_OFS   = 'h100;
  localparam int          ERR_OFS    = 'h108;
  localparam int          ERR_ADDR_B = 31;
  localparam int          ERR_DW_B   = 30;
  localparam int          ERR_ACT_LSB = 9;
  localparam int          ERR_CRD_LSB = 0;

  function automatic logic [31:0] err_mask(int n_ch);
    logic [31:0] m;
    m = '0;
    m[ERR_ADDR_B] = 1'b1;
    m[ERR_DW_B]   = 1'b1;
    for (int i = 0; i < n_ch; i++) begin
      m[ERR_ACT_LSB + i] = 1'b1;
      m[ERR_CRD_LSB + i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/txdma_chan_ctl.sv
module txdma_chan_ctl
  import txdma_stat_pkg::*;
#(
  parameter int CRED_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              grant_i,
  input  logic              issue_i,
  output logic [31:0]       cfg_o,
  output logic [CRED_W-1:0] credit_o,
  output logic              run_o,
  output logic              eof_o,
  output logic              cen_o
);
  localparam logic [CRED_W-1:0] CRED_MAX = {CRED_W{1'b1}};

  logic [31:0]       cfg_q;
  logic [CRED_W-1:0] cnt_q;
  ch_mode_e          mode;

  assign mode = ch_mode_e'(cfg_q[31:30]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i & CFG_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     cnt_q <= '0;
    else if (mode == MODE_OFF)                       cnt_q <= '0;
    else if (grant_i && !issue_i && cnt_q != CRED_MAX) cnt_q <= cnt_q + 1'b1;
    else if (issue_i && !grant_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cfg_o    = cfg_q;
  assign credit_o = cnt_q;
  assign run_o    = (mode == MODE_RUN);
  assign eof_o    = (mode == MODE_EOF);
  assign cen_o    = cfg_q[3];

  AST_CREDIT_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_OFF) |=> (cnt_q == '0)); // R5
  AST_CREDIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode != MODE_OFF) && (grant_i == issue_i)) |=> $stable(cnt_q)); // R4
  AST_CREDIT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode != MODE_OFF) && cnt_q == CRED_MAX && grant_i) |=> (cnt_q == CRED_MAX)); // R6
  AST_CREDIT_NO_UNDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !grant_i) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/txdma_err_log.sv
module txdma_err_log
  import txdma_stat_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic [31:0] clr_data_i,
  input  logic [31:0] set_i,
  output logic [31:0] err_o
);
  localparam logic [31:0] MASK = err_mask(N_CH);

  logic [31:0] err_q, clr_vec;

  assign clr_vec = clr_i ? (clr_data_i & MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= ((err_q & ~clr_vec) | set_i) & MASK;  // set beats clear
  end

  assign err_o = err_q;

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((err_q & $past(set_i & MASK)) == $past(set_i & MASK))); // R12
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_vec == '0) |=> ((err_q & $past(err_q)) == $past(err_q))); // R11
endmodule

// File: rtl/txdma_stat_unit.sv
module txdma_stat_unit
  import txdma_stat_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CRED_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [N_CH-1:0]   credit_grant_i,
  input  logic [N_CH-1:0]   req_issue_i,
  input  logic [N_CH-1:0]   act_cmd_i,
  input  logic [N_CH-1:0]   req_buf_full_i,
  input  logic [N_CH-1:0]   fifo_full_i,
  input  logic [N_CH-1:0]   buf_empty_i,
  input  logic [N_CH-1:0]   no_pend_i,
  input  logic              addr_err_i,
  input  logic              dword_err_i,
  output logic [N_CH-1:0]   run_o,
  output logic [N_CH-1:0]   eof_pause_o,
  output logic [N_CH-1:0]   credit_en_o,
  output logic [N_CH-1:0]   idle_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] ERR_A  = ADDR_W'(ERR_OFS);
  localparam logic [31:0]       ERR_M  = err_mask(N_CH);

  logic [31:0]       cfg_w  [N_CH];
  logic [CRED_W-1:0] cred_w [N_CH];
  logic [31:0]       err_w, set_w;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic we_ch;
    assign we_ch = reg_we_i && (reg_addr_i == ADDR_W'(g * CH_STRIDE));
    txdma_chan_ctl #(.CRED_W(CRED_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (we_ch),
      .cfg_wdata_i(reg_wdata_i),
      .grant_i    (credit_grant_i[g]),
      .issue_i    (req_issue_i[g]),
      .cfg_o      (cfg_w[g]),
      .credit_o   (cred_w[g]),
      .run_o      (run_o[g]),
      .eof_o      (eof_pause_o[g]),
      .cen_o      (credit_en_o[g])
    );
  end

  always_comb begin
    set_w = '0;
    set_w[ERR_ADDR_B] = addr_err_i;
    set_w[ERR_DW_B]   = dword_err_i;
    for (int i = 0; i < N_CH; i++) begin
      set_w[ERR_ACT_LSB + i] = act_cmd_i[i] & req_buf_full_i[i];
      set_w[ERR_CRD_LSB + i] = fifo_full_i[i] & (cred_w[i] != '0);
    end
  end

  txdma_err_log #(.N_CH(N_CH)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (reg_we_i && (reg_addr_i == ERR_A)),
    .clr_data_i(reg_wdata_i),
    .set_i     (set_w),
    .err_o     (err_w)
  );

  assign idle_o = buf_empty_i & no_pend_i;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == STAT_A) begin
      reg_rdata_o[24 +: N_CH] = buf_empty_i;
      reg_rdata_o[16 +: N_CH] = no_pend_i;
    end
    if (reg_addr_i == ERR_A) reg_rdata_o = err_w;
    for (int i = 0; i < N_CH; i++) begin
      if (reg_addr_i == ADDR_W'(i * CH_STRIDE))            reg_rdata_o = cfg_w[i];
      if (reg_addr_i == ADDR_W'(i * CH_STRIDE + CRED_OFS)) reg_rdata_o = {{(32-CRED_W){1'b0}}, cred_w[i]};
    end
  end

  AST_ERR_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ERR_A) |-> ((reg_rdata_o & ~ERR_M) == '0)); // R11
  AST_CRED_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_i[0] && cred_w[0] != '0) |=> err_w[ERR_CRD_LSB]); // R8
  AST_ACT_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_cmd_i[0] && req_buf_full_i[0]) |=> err_w[ERR_ACT_LSB]); // R9
endmodule

// File: tb/txdma_stat_unit_tb_top.sv
module txdma_stat_unit_tb_top;
  localparam int NCH = 8;
  localparam int AW  = 9;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 0;
  logic [NCH-1:0] grant = '0, issue = '0, act = '0, rfull = '0, ffull = '0;
  logic [NCH-1:0] bempty = '0, npend = '0;
  logic aerr = 0, derr = 0;
  logic [NCH-1:0] run, eofp, cen, idle;

  always #5 clk = ~clk;

  txdma_stat_unit #(.N_CH(NCH), .CRED_W(8), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we), .reg_rdata_o(reg_rdata),
    .credit_grant_i(grant), .req_issue_i(issue), .act_cmd_i(act), .req_buf_full_i(rfull),
    .fifo_full_i(ffull), .buf_empty_i(bempty), .no_pend_i(npend),
    .addr_err_i(aerr), .dword_err_i(derr),
    .run_o(run), .eof_pause_o(eofp), .credit_en_o(cen), .idle_o(idle)
  );

  typedef struct {
    int          kind;  // 0 rdata 1 idle 2 run 3 eof 4 cen
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  chk_ev;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  // monitor
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act_v;
      it = exp_q.pop_front();
      case (it.kind)
        0: act_v = reg_rdata;
        1: act_v = 32'(idle);
        2: act_v = 32'(run);
        3: act_v = 32'(eofp);
        default: act_v = 32'(cen);
      endcase
      n_run++;
      if (act_v !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act_v, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    #2;
    exp_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    push(0, exp, tag);
  endtask

  task automatic out_chk(int kind, logic [31:0] exp, string tag);
    @(negedge clk);
    push(kind, exp, tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic pulse(ref logic [NCH-1:0] sig, input logic [NCH-1:0] v);
    @(negedge clk);
    sig = v;
    @(negedge clk);
    sig = '0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  localparam logic [AW-1:0] STAT = 9'h100, ERR = 9'h108;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(9'h000, 32'h0, "R1 cfg ch0");
    rd(9'h0E0, 32'h0, "R1 cfg ch7");
    rd(9'h064, 32'h0, "R1 credit ch3");
    rd(ERR,    32'h0, "R1 error reg");
    // R2 masking and stride
    wr(9'h040, 32'hFFFF_FFFF);
    rd(9'h040, 32'hC000_0008, "R2 cfg ch2 masked");
    rd(9'h020, 32'h0, "R2 cfg ch1 untouched");
    rd(9'h060, 32'h0, "R2 cfg ch3 untouched");
    // R3 mode decode
    wr(9'h040, 32'h8000_0008);
    wr(9'h0A0, 32'h4000_0000);
    out_chk(2, 32'h04, "R3 run_o");
    out_chk(3, 32'h20, "R3 eof_pause_o");
    out_chk(4, 32'h04, "R3 credit_en_o");
    // R4 counting
    repeat (3) pulse(grant, 8'h04);
    rd(9'h044, 32'd3, "R4 credit after 3 grants");
    @(negedge clk); grant = 8'h04; issue = 8'h04;
    @(negedge clk); grant = '0; issue = '0;
    rd(9'h044, 32'd3, "R4 grant and issue together");
    pulse(issue, 8'h04);
    rd(9'h044, 32'd2, "R4 credit after issue");
    // R5 off mode
    pulse(grant, 8'h01);
    rd(9'h004, 32'd0, "R5 grant ignored when off");
    wr(9'h040, 32'h0);
    rd(9'h044, 32'd0, "R5 cleared on switch to off");
    wr(9'h040, 32'h8000_0008);
    // R6 saturation
    pulse(issue, 8'h04);
    rd(9'h044, 32'd0, "R6 no underflow");
    @(negedge clk); grant = 8'h04;
    repeat (260) @(negedge clk);
    grant = '0;
    rd(9'h044, 32'd255, "R6 saturate high");
    pulse(issue, 8'h04);
    rd(9'h044, 32'd254, "R6 decrement from max");
    // R8 credit desync
    pulse(ffull, 8'h05);
    rd(ERR, 32'h0000_0004, "R8 credit err only nonzero channel");
    // R9 activate while busy
    @(negedge clk); rfull = 8'h02; act = 8'h0A;
    @(negedge clk); rfull = '0; act = '0;
    rd(ERR, 32'h0000_0404, "R9 activate err only full channel");
    // R10 global errors
    @(negedge clk); aerr = 1; derr = 1;
    @(negedge clk); aerr = 0; derr = 0;
    rd(ERR, 32'hC000_0404, "R10 addr and dword errors");
    // R11 write-one-to-clear
    wr(ERR, 32'h0);
    rd(ERR, 32'hC000_0404, "R11 write zero no effect");
    wr(ERR, 32'h0000_0004);
    rd(ERR, 32'hC000_0400, "R11 clear single bit");
    wr(ERR, 32'hFFFF_FFFF);
    rd(ERR, 32'h0, "R11 clear all");
    // R12 event beats clear
    @(negedge clk);
    reg_addr = ERR; reg_wdata = 32'h8000_0000; reg_we = 1; aerr = 1;
    @(negedge clk);
    reg_we = 0; aerr = 0;
    rd(ERR, 32'h8000_0000, "R12 event wins over clear");
    wr(ERR, 32'h8000_0000);
    rd(ERR, 32'h0, "R12 later clear works");
    // R7 status word
    @(negedge clk); bempty = 8'hA5; npend = 8'h0F;
    rd(STAT, 32'hA50F_0000, "R7 status word");
    out_chk(1, 32'h05, "R7 idle_o");
    @(negedge clk);
    #3;
    done = 1;
    report();
  end
endmodule